// File: doc/BRIEF.md
# Saturating Dual-Halfword Dot Product Unit

This unit takes two 32-bit operands. Each operand holds two signed 16-bit halfwords. The unit multiplies the upper halfwords together and the lower halfwords together, and adds the two products without losing any bits. It then clamps the sum to the signed 32-bit range. The result leaves through a writeback port exactly three cycles after issue, and the same port writes it into a small local destination register file.

A guard word travels with each issue. Only bit 0 of the guard decides whether the result is written. A caller with no predicate drives the guard as 1. A new operation may issue on every cycle, and the guard and destination index move through the pipeline in step with the data. A combinational read port shows the contents of any destination register.

Top module: `dot2_sat_unit`

## Requirements
- R1: Each operand splits into an upper halfword (bits 31:16) and a lower halfword (bits 15:0). Each halfword is treated as a signed two's-complement value. The result is upper×upper plus lower×lower.
- R2: The sum is formed at 33-bit signed precision, so no product or partial sum wraps. For example, 0x80008000 with 0x80007FFF gives 0x00008000, and 0x80008000 with 0x7FFF7FFF gives 0x80010000.
- R3: A sum above 0x7FFFFFFF is clamped to 0x7FFFFFFF, and a sum below 0x80000000 is clamped to 0x80000000. Both operands equal to 0x80008000 give 0x7FFFFFFF.
- R4: A result issued in cycle n appears on the writeback port in cycle n+3. The write into the register file lands at the clock edge that closes cycle n+3.
- R5: wb_valid_o is 1 in cycle n+3 only if an issue in cycle n had guard bit 0 equal to 1. Guard bits 31:1 have no effect. When bit 0 is 0, the destination register keeps its old value.
- R6: wb_idx_o in cycle n+3 equals the dst_idx_i given with the issue in cycle n.
- R7: rd_data_o combinationally shows the register selected by rd_idx_i. A register changes only when a guarded writeback targets it.
- R8: Issues on consecutive cycles each produce their own result, in issue order, with no bubbles.
- R9: After reset, wb_valid_o is 0 and every destination register reads 0.
- R10: Operands 0x00020003 and 0x00010002 give 0x00000008. Operands 0xFF9C0064 and 0x0064FF9C give 0xFFFFB1E0. Operands 0x00020003 and 0x0064FF9C give 0xFFFFFF9C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Operation issued this cycle |
| src_a_i | input | 32 | First operand, two signed halfwords |
| src_b_i | input | 32 | Second operand, two signed halfwords |
| guard_i | input | 32 | Predicate word; only bit 0 is used |
| dst_idx_i | input | 3 | Destination register index |
| wb_valid_o | output | 1 | Guarded result is being written this cycle |
| wb_idx_o | output | 3 | Destination index of the result |
| wb_data_o | output | 32 | Saturated result |
| rd_idx_i | input | 3 | Register file read index |
| rd_data_o | output | 32 | Register file read data |

## Verification
The writeback signals for an issue are due in the third cycle after it, and the register file shows the written value one cycle after that. The bench drives and samples on falling edges. It keeps a queue that is primed with three idle entries, so every sample pops the expectation that belongs to the issue made three samples earlier. A shadow register array is updated only after that cycle's read data has been compared, which matches the one-cycle lag of the register-file write.

// File: rtl/dot2_pkg.sv
package dot2_pkg;
  localparam int unsigned DEF_HALF_W = 16;
  localparam int unsigned DEF_LANES  = 2;
  localparam int unsigned DEF_NREGS  = 8;
  // Register stages from issue to writeback.
  localparam int unsigned PIPE_DEPTH = 3;
endpackage

// File: rtl/dot2_lane_mul.sv
module dot2_lane_mul #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned PROD_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] a_i,
  input  logic [HALF_W-1:0] b_i,
  output logic [PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] a_ext, b_ext, prod_q;

  always_comb begin
    a_ext = PROD_W'($signed(a_i));
    b_ext = PROD_W'($signed(b_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_q <= '0;
    else         prod_q <= a_ext * b_ext;
  end

  assign prod_o = prod_q;

  AST_LANE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(a_i) == '0 || $past(b_i) == '0) |-> prod_o == '0); // R1
  AST_LANE_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(a_i) != '0 && $past(b_i) != '0) |-> prod_o[PROD_W-1] == ($past(a_i[HALF_W-1]) ^ $past(b_i[HALF_W-1]))); // R1
endmodule

// File: rtl/dot2_sum_sat.sv
module dot2_sum_sat #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned PROD_W = 32,
  parameter int unsigned OUT_W  = 32,
  localparam int unsigned SUM_W = PROD_W + $clog2(LANES),
  localparam int unsigned HI_W  = SUM_W - OUT_W + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [LANES-1:0][PROD_W-1:0] prods_i,
  output logic [OUT_W-1:0]             res_o
);
  localparam logic [OUT_W-1:0] SAT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] SAT_MIN = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic signed [SUM_W-1:0] MAX_EXT = {{HI_W{1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] MIN_EXT = {{HI_W{1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [SUM_W-1:0] acc, sum_q;
  logic [HI_W-1:0]         hi_bits;
  logic                    fits;
  logic [OUT_W-1:0]        sat_val, res_q;

  // Stage 2: full-precision sum.
  always_comb begin
    acc = '0;
    for (int l = 0; l < LANES; l++) acc = acc + SUM_W'($signed(prods_i[l]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= acc;
  end

  // Stage 3: clamp to OUT_W signed.
  always_comb begin
    hi_bits = sum_q[SUM_W-1:OUT_W-1];
    fits    = (&hi_bits) | ~(|hi_bits);
    if (fits)               sat_val = sum_q[OUT_W-1:0];
    else if (sum_q[SUM_W-1]) sat_val = SAT_MIN;
    else                    sat_val = SAT_MAX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= sat_val;
  end

  assign res_o = res_q;

  AST_SAT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sum_q) > MAX_EXT) |-> res_q == SAT_MAX); // R3
  AST_SAT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sum_q) < MIN_EXT) |-> res_q == SAT_MIN); // R3
  AST_SAT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sum_q) <= MAX_EXT && $past(sum_q) >= MIN_EXT) |-> res_q == $past(sum_q[OUT_W-1:0])); // R2
endmodule

// File: rtl/dot2_ctrl_pipe.sv
module dot2_ctrl_pipe #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             wr_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [DEPTH-1:0]            wr_q;
  logic [DEPTH-1:0][IDX_W-1:0] idx_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          wr_q[g]  <= 1'b0;
          idx_q[g] <= '0;
        end else begin
          wr_q[g]  <= wr_i;
          idx_q[g] <= idx_i;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          wr_q[g]  <= 1'b0;
          idx_q[g] <= '0;
        end else begin
          wr_q[g]  <= wr_q[g-1];
          idx_q[g] <= idx_q[g-1];
        end
      end
    end
  end

  assign wr_o  = wr_q[DEPTH-1];
  assign idx_o = idx_q[DEPTH-1];

  AST_CTRL_ONEHOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q[0] == $past(wr_i)); // R8
endmodule

// File: rtl/dot2_regfile.sv
module dot2_regfile #(
  parameter int unsigned NREGS = 8,
  parameter int unsigned W     = 32,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [W-1:0]     rd_data_o
);
  logic [NREGS-1:0][W-1:0] mem_q;

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[r] <= '0;
      else if (we_i && wr_idx_i == IDX_W'(r)) mem_q[r] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];

  AST_RF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q)); // R7
  AST_RF_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(wr_idx_i)] == $past(wr_data_i)); // R7
endmodule

// File: rtl/dot2_sat_unit.sv
module dot2_sat_unit
  import dot2_pkg::*;
#(
  parameter int unsigned HALF_W = DEF_HALF_W,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned NREGS  = DEF_NREGS,
  localparam int unsigned OP_W   = HALF_W * LANES,
  localparam int unsigned PROD_W = 2 * HALF_W,
  localparam int unsigned OUT_W  = PROD_W,
  localparam int unsigned IDX_W  = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_valid_i,
  input  logic [OP_W-1:0]  src_a_i,
  input  logic [OP_W-1:0]  src_b_i,
  input  logic [OP_W-1:0]  guard_i,
  input  logic [IDX_W-1:0] dst_idx_i,
  output logic             wb_valid_o,
  output logic [IDX_W-1:0] wb_idx_o,
  output logic [OUT_W-1:0] wb_data_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [OUT_W-1:0] rd_data_o
);
  logic [LANES-1:0][PROD_W-1:0] prods;
  logic                         wr_req;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dot2_lane_mul #(.HALF_W(HALF_W)) u_mul (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .a_i    (src_a_i[l*HALF_W +: HALF_W]),
      .b_i    (src_b_i[l*HALF_W +: HALF_W]),
      .prod_o (prods[l])
    );
  end

  dot2_sum_sat #(.LANES(LANES), .PROD_W(PROD_W), .OUT_W(OUT_W)) u_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .prods_i (prods),
    .res_o   (wb_data_o)
  );

  assign wr_req = issue_valid_i & guard_i[0];

  dot2_ctrl_pipe #(.DEPTH(PIPE_DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_req),
    .idx_i  (dst_idx_i),
    .wr_o   (wb_valid_o),
    .idx_o  (wb_idx_o)
  );

  dot2_regfile #(.NREGS(NREGS), .W(OUT_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wb_valid_o),
    .wr_idx_i  (wb_idx_o),
    .wr_data_i (wb_data_o),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o)
  );

  AST_WB_GUARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(issue_valid_i && guard_i[0], 3)); // R5
  AST_WB_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(issue_valid_i && !guard_i[0], 3) |-> !wb_valid_o); // R5
  AST_WB_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> wb_idx_o == $past(dst_idx_i, 3)); // R6
  AST_WB_DUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(issue_valid_i && guard_i[0], 3) |-> wb_valid_o); // R4
endmodule

// File: tb/dot2_sat_unit_bench.sv
module dot2_sat_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, guard = '0;
  logic [2:0]  dst_idx = '0, rd_idx = '0;
  logic        wb_valid;
  logic [2:0]  wb_idx;
  logic [31:0] wb_data, rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic        wr;
    logic [2:0]  idx;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] shadow[8];

  always #2 clk = ~clk;

  dot2_sat_unit u_dot2_sat_unit (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .issue_valid_i (issue_valid),
    .src_a_i       (src_a),
    .src_b_i       (src_b),
    .guard_i       (guard),
    .dst_idx_i     (dst_idx),
    .wb_valid_o    (wb_valid),
    .wb_idx_o      (wb_idx),
    .wb_data_o     (wb_data),
    .rd_idx_i      (rd_idx),
    .rd_data_o     (rd_data)
  );

  function automatic logic [31:0] ref_dot(input logic [31:0] a, input logic [31:0] b);
    longint ah = longint'($signed(a[31:16]));
    longint al = longint'($signed(a[15:0]));
    longint bh = longint'($signed(b[31:16]));
    longint bl = longint'($signed(b[15:0]));
    longint s  = ah * bh + al * bl;
    if (s > 64'sd2147483647)  s = 64'sd2147483647;
    if (s < -64'sd2147483648) s = -64'sd2147483648;
    return s[31:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Compare this cycle's outputs with the expectation from three issues ago.
  task automatic check_cycle();
    exp_t e = exp_q.pop_front();
    chk(wb_valid == e.wr, {e.tag, " R4 R5 wb_valid"}, 32'(wb_valid), 32'(e.wr));
    if (e.wr) begin
      chk(wb_idx == e.idx, {e.tag, " R6 wb_idx"}, 32'(wb_idx), 32'(e.idx));
      chk(wb_data == e.data, {e.tag, " wb_data"}, wb_data, e.data);
    end
    chk(rd_data == shadow[rd_idx], "R7 rd_data", rd_data, shadow[rd_idx]);
    if (e.wr) shadow[e.idx] = e.data;
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] g, input logic [2:0] d, input logic [2:0] r,
                      input string tag);
    exp_t e;
    @(negedge clk);
    check_cycle();
    issue_valid = v;
    src_a = a;
    src_b = b;
    guard = g;
    dst_idx = d;
    rd_idx = r;
    e.wr = v & g[0];
    e.idx = d;
    e.data = ref_dot(a, b);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  function automatic logic [31:0] pick_op(input int sel);
    case (sel)
      0: return 32'h80008000;
      1: return 32'h7FFF7FFF;
      2: return 32'h80007FFF;
      3: return 32'hFFFFFFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    exp_t idle;
    idle.wr = 1'b0;
    idle.idx = '0;
    idle.data = '0;
    idle.tag = "idle";
    for (int i = 0; i < 8; i++) shadow[i] = '0;
    for (int i = 0; i < 3; i++) exp_q.push_back(idle);
    repeat (3) @(posedge clk);
    // R9: reset state
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rd_idx = 3'(i);
      #1;
      chk(rd_data == '0, "R9 reset rd_data", rd_data, '0);
      chk(wb_valid == 1'b0, "R9 reset wb_valid", 32'(wb_valid), '0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R10: documented operand pairs
    step(1, 32'h00020003, 32'h00010002, 32'h1, 3'd1, 3'd0, "R10 ex1");
    step(1, 32'hFF9C0064, 32'h0064FF9C, 32'h1, 3'd2, 3'd0, "R10 ex2");
    step(1, 32'h00020003, 32'h0064FF9C, 32'h1, 3'd3, 3'd0, "R10 ex3");
    // R3: the saturating input
    step(1, 32'h80008000, 32'h80008000, 32'h1, 3'd4, 3'd1, "R3 sat");
    // R2: near-extreme sums without clamping
    step(1, 32'h80008000, 32'h80007FFF, 32'h1, 3'd5, 3'd2, "R2 mixed");
    step(1, 32'h80008000, 32'h7FFF7FFF, 32'h1, 3'd6, 3'd3, "R2 min");
    step(1, 32'h7FFF7FFF, 32'h7FFF7FFF, 32'h1, 3'd7, 3'd4, "R2 max");
    // R1: signs on each lane separately
    step(1, 32'hFFFF0001, 32'h00050007, 32'h1, 3'd0, 3'd5, "R1 lanes");
    // R5: guard upper bits ignored; bit0=0 suppresses write to reg 2
    step(1, 32'h00010001, 32'h00010001, 32'hFFFFFFFE, 3'd2, 3'd6, "R5 off");
    step(1, 32'h00030000, 32'h00030000, 32'h80000001, 3'd6, 3'd7, "R5 on");
    step(0, 32'h00010001, 32'h00010001, 32'h1, 3'd2, 3'd2, "R5 idle");
    for (int i = 0; i < 4; i++) step(0, '0, '0, '0, '0, 3'd2, "R5 hold");

    // R8: back-to-back random issues
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) != 0, pick_op($urandom % 8), pick_op($urandom % 8),
           $urandom, 3'($urandom), 3'($urandom), "R8 R1 rand");
    end
    for (int i = 0; i < 8; i++) step(0, '0, '0, '0, '0, 3'(i), "drain");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule